// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block caches recent virtual-to-physical page translations for a 32-bit address space with 4 KB pages. On a lookup strobe it compares the page number of the incoming virtual address against every stored entry at once, checks the access type against the matching entry's permissions, and one cycle later reports a hit, a miss or a protection fault together with the translated physical address. The low 12 address bits pass through untouched. The upper 20 bits are replaced by the stored frame number.

Each entry holds a valid flag, a virtual page number, a frame number, three permission bits and a modified flag. A permitted write that hits an entry sets that entry's modified flag, and each hit response reports the flag. The page-table walker that runs after a miss loads entries through a fill port at an index of its own choosing. A single invalidate input empties the whole table in one cycle. Replacement policy and table walking stay outside the block.

Top module: `tlb_fa`

## Requirements
- R1: While reset is asserted every entry becomes invalid and the outputs rsp_hit, rsp_miss, rsp_fault, rsp_dirty and rsp_paddr are all zero. After reset, a lookup of any address misses.
- R2: Responses are registered. A lookup strobed on one rising edge is reported on the outputs after that edge. After an edge with no strobe, rsp_hit, rsp_miss, rsp_fault and rsp_dirty are zero and rsp_paddr holds its last value. Every strobed lookup produces exactly one of rsp_hit and rsp_miss.
- R3: On a hit, rsp_paddr equals the entry's 20-bit frame number in bits 31:12 followed by lookup address bits 11:0 unchanged. The virtual page number is address bits 31:12.
- R4: When no valid entry holds the page number, rsp_miss is 1 and rsp_hit, rsp_fault, rsp_dirty and rsp_paddr are 0.
- R5: Permission bit 0 allows read, bit 1 allows write and bit 2 allows execute. The access code is 00 for read, 01 for write, 10 for execute, and 11 for an access that no entry permits. A hit whose required bit is clear gives rsp_hit=1 and rsp_fault=1. Otherwise rsp_fault is 0.
- R6: A write hit with write permission sets the entry's modified flag. On a hit, rsp_dirty reports the flag as it stands after the lookup, so the write hit itself already shows 1.
- R7: A write that faults leaves the modified flag unchanged.
- R8: A fill writes valid, page number, frame number, permissions and modified flag into the entry at fl_idx. A lookup in the same cycle still sees the old contents. A fill with valid 0 removes the entry. A fill overrides a modified-flag update to the same entry in the same cycle.
- R9: An invalidate makes every entry invalid in one cycle and takes priority over a fill in the same cycle.
- R10: If several valid entries hold the same page number, the entry with the lowest index supplies the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush_all | input | 1 | Invalidate every entry |
| lk_valid | input | 1 | Lookup strobe |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_acc | input | 2 | Access code: 00 read, 01 write, 10 execute, 11 none |
| fl_en | input | 1 | Fill strobe |
| fl_idx | input | 4 | Entry index written by the fill |
| fl_valid | input | 1 | Valid flag for the filled entry |
| fl_vpn | input | 20 | Virtual page number for the filled entry |
| fl_pfn | input | 20 | Frame number for the filled entry |
| fl_perm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| fl_dirty | input | 1 | Initial modified flag for the filled entry |
| rsp_hit | output | 1 | Registered: translation found |
| rsp_miss | output | 1 | Registered: no valid entry matched |
| rsp_fault | output | 1 | Registered: access not permitted on a hit |
| rsp_dirty | output | 1 | Registered: modified flag of the hit entry |
| rsp_paddr | output | 32 | Registered physical address |

## Verification
The hardest conditions to create are the same-cycle collisions: a lookup that hits while a fill rewrites the table, a fill that lands in the same cycle as an invalidate, and a permitted write whose modified-flag update coincides with a fill of that same entry. The bench drives these by asserting the fill, invalidate and lookup strobes on one clock edge. It then confirms the resolved state with later lookups. Before that, the bench fills all sixteen entries so that the eight permission combinations each appear twice. It sweeps all four access codes over every entry, and it plants duplicate page numbers to check which entry wins.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'b00,
      ACC_WRITE = 2'b01,
      ACC_EXEC  = 2'b10,
      ACC_NONE  = 2'b11
   } acc_e;

   localparam int PERM_W  = 3;
   localparam int PERM_RD = 0;
   localparam int PERM_WR = 1;
   localparam int PERM_EX = 2;

   function automatic logic perm_allows(input logic [PERM_W-1:0] perm, input acc_e acc);
      logic ok;
      case (acc)
         ACC_READ:  ok = perm[PERM_RD];
         ACC_WRITE: ok = perm[PERM_WR];
         ACC_EXEC:  ok = perm[PERM_EX];
         default:   ok = 1'b0;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/tlb_store.sv
module tlb_store
   import tlb_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int PFN_W   = 20,
   parameter int IDX_W   = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                flush,
   input  logic                fl_en,
   input  logic [IDX_W-1:0]    fl_idx,
   input  logic                fl_valid,
   input  logic [VPN_W-1:0]    fl_vpn,
   input  logic [PFN_W-1:0]    fl_pfn,
   input  logic [PERM_W-1:0]   fl_perm,
   input  logic                fl_dirty,
   input  logic                mark_en,
   input  logic [IDX_W-1:0]    mark_idx,
   input  logic [VPN_W-1:0]    cmp_vpn,
   output logic [ENTRIES-1:0]  match_o,
   output logic [PFN_W-1:0]    pfn_o   [ENTRIES],
   output logic [PERM_W-1:0]   perm_o  [ENTRIES],
   output logic [ENTRIES-1:0]  dirty_o
);

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      logic               v_q;
      logic               d_q;
      logic [VPN_W-1:0]   vpn_q;
      logic [PFN_W-1:0]   pfn_q;
      logic [PERM_W-1:0]  perm_q;
      logic               fill_here;
      logic               mark_here;

      assign fill_here = fl_en   && (fl_idx   == IDX_W'(g));
      assign mark_here = mark_en && (mark_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q    <= 1'b0;
            d_q    <= 1'b0;
            vpn_q  <= '0;
            pfn_q  <= '0;
            perm_q <= '0;
         end else if (flush) begin
            v_q    <= 1'b0;
         end else if (fill_here) begin
            v_q    <= fl_valid;
            d_q    <= fl_dirty;
            vpn_q  <= fl_vpn;
            pfn_q  <= fl_pfn;
            perm_q <= fl_perm;
         end else if (mark_here) begin
            d_q    <= 1'b1;
         end
      end

      assign match_o[g] = v_q && (vpn_q == cmp_vpn);
      assign pfn_o[g]   = pfn_q;
      assign perm_o[g]  = perm_q;
      assign dirty_o[g] = d_q;
   end

endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
   parameter int ENTRIES = 16,
   parameter int IDX_W   = 4
) (
   input  logic [ENTRIES-1:0] match_i,
   output logic               any_o,
   output logic [IDX_W-1:0]   idx_o
);

   always_comb begin
      idx_o = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match_i[i]) idx_o = IDX_W'(i);
      end
   end

   assign any_o = |match_i;

endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
   import tlb_pkg::*;
#(
   parameter int  ENTRIES   = 16,
   parameter int  VA_W      = 32,
   parameter int  PA_W      = 32,
   parameter int  PAGE_BITS = 12,
   localparam int VPN_W     = VA_W - PAGE_BITS,
   localparam int PFN_W     = PA_W - PAGE_BITS,
   localparam int IDX_W     = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_all,
   input  logic              lk_valid,
   input  logic [VA_W-1:0]   lk_vaddr,
   input  logic [1:0]        lk_acc,
   input  logic              fl_en,
   input  logic [IDX_W-1:0]  fl_idx,
   input  logic              fl_valid,
   input  logic [VPN_W-1:0]  fl_vpn,
   input  logic [PFN_W-1:0]  fl_pfn,
   input  logic [2:0]        fl_perm,
   input  logic              fl_dirty,
   output logic              rsp_hit,
   output logic              rsp_miss,
   output logic              rsp_fault,
   output logic              rsp_dirty,
   output logic [PA_W-1:0]   rsp_paddr
);

   if (ENTRIES < 2 || ENTRIES > 63) begin : g_bad_entries
      $error("tlb_fa: ENTRIES must lie in 2..63");
   end
   if (PAGE_BITS < 1 || PAGE_BITS >= VA_W || PAGE_BITS >= PA_W) begin : g_bad_page
      $error("tlb_fa: PAGE_BITS must be below both address widths");
   end

   logic [VPN_W-1:0]   cmp_vpn;
   logic [ENTRIES-1:0] match_vec;
   logic [PFN_W-1:0]   pfn_arr  [ENTRIES];
   logic [PERM_W-1:0]  perm_arr [ENTRIES];
   logic [ENTRIES-1:0] dirty_vec;
   logic               any_hit;
   logic [IDX_W-1:0]   hit_idx;
   logic               access_ok;
   logic               mark_en;
   acc_e               acc;

   assign cmp_vpn = lk_vaddr[VA_W-1:PAGE_BITS];
   assign acc     = acc_e'(lk_acc);

   tlb_store #(
      .ENTRIES (ENTRIES),
      .VPN_W   (VPN_W),
      .PFN_W   (PFN_W),
      .IDX_W   (IDX_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush_all),
      .fl_en    (fl_en),
      .fl_idx   (fl_idx),
      .fl_valid (fl_valid),
      .fl_vpn   (fl_vpn),
      .fl_pfn   (fl_pfn),
      .fl_perm  (fl_perm),
      .fl_dirty (fl_dirty),
      .mark_en  (mark_en),
      .mark_idx (hit_idx),
      .cmp_vpn  (cmp_vpn),
      .match_o  (match_vec),
      .pfn_o    (pfn_arr),
      .perm_o   (perm_arr),
      .dirty_o  (dirty_vec)
   );

   tlb_pick #(
      .ENTRIES (ENTRIES),
      .IDX_W   (IDX_W)
   ) u_pick (
      .match_i (match_vec),
      .any_o   (any_hit),
      .idx_o   (hit_idx)
   );

   assign access_ok = perm_allows(perm_arr[hit_idx], acc);
   assign mark_en   = lk_valid && any_hit && (acc == ACC_WRITE) && access_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_hit   <= 1'b0;
         rsp_miss  <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_dirty <= 1'b0;
         rsp_paddr <= '0;
      end else begin
         rsp_hit   <= lk_valid && any_hit;
         rsp_miss  <= lk_valid && !any_hit;
         rsp_fault <= lk_valid && any_hit && !access_ok;
         rsp_dirty <= lk_valid && any_hit && (dirty_vec[hit_idx] || mark_en);
         if (lk_valid) begin
            rsp_paddr <= any_hit ? {pfn_arr[hit_idx], lk_vaddr[PAGE_BITS-1:0]} : '0;
         end
      end
   end

endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int PAGE_BITS = 12
) (
   input logic            clk,
   input logic            rst_n,
   input logic            flush_all,
   input logic            lk_valid,
   input logic [VA_W-1:0] lk_vaddr,
   input logic            rsp_hit,
   input logic            rsp_miss,
   input logic            rsp_fault,
   input logic            rsp_dirty,
   input logic [PA_W-1:0] rsp_paddr
);

   // R2
   one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> $countones({rsp_hit, rsp_miss}) == 1);

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !rsp_hit && !rsp_miss && !rsp_fault && !rsp_dirty);

   // R3
   offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> (!rsp_hit || rsp_paddr[PAGE_BITS-1:0] == $past(lk_vaddr[PAGE_BITS-1:0])));

   // R4
   miss_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_miss |-> !rsp_fault && !rsp_dirty && rsp_paddr == '0);

   // R5
   fault_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> rsp_hit);

   // R9
   flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(flush_all) && lk_valid) |=> rsp_miss);

endmodule

bind tlb_fa tlb_fa_chk #(
   .VA_W      (VA_W),
   .PA_W      (PA_W),
   .PAGE_BITS (PAGE_BITS)
) u_tlb_fa_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .flush_all (flush_all),
   .lk_valid  (lk_valid),
   .lk_vaddr  (lk_vaddr),
   .rsp_hit   (rsp_hit),
   .rsp_miss  (rsp_miss),
   .rsp_fault (rsp_fault),
   .rsp_dirty (rsp_dirty),
   .rsp_paddr (rsp_paddr)
);

// File: tb/test_tlb_fa.sv
module test_tlb_fa;

   localparam int CLK_PERIOD = 10;
   localparam int N = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush_all = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_vaddr = '0;
   logic [1:0]  lk_acc = '0;
   logic        fl_en = 1'b0;
   logic [3:0]  fl_idx = '0;
   logic        fl_valid = 1'b0;
   logic [19:0] fl_vpn = '0;
   logic [19:0] fl_pfn = '0;
   logic [2:0]  fl_perm = '0;
   logic        fl_dirty = 1'b0;
   logic        rsp_hit, rsp_miss, rsp_fault, rsp_dirty;
   logic [31:0] rsp_paddr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   bit          m_v    [N];
   bit          m_d    [N];
   logic [19:0] m_vpn  [N];
   logic [19:0] m_pfn  [N];
   logic [2:0]  m_perm [N];
   logic [31:0] last_pa = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tlb_fa i_tlb_fa (
      .clk(clk), .rst_n(rst_n), .flush_all(flush_all),
      .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_acc(lk_acc),
      .fl_en(fl_en), .fl_idx(fl_idx), .fl_valid(fl_valid), .fl_vpn(fl_vpn),
      .fl_pfn(fl_pfn), .fl_perm(fl_perm), .fl_dirty(fl_dirty),
      .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
      .rsp_dirty(rsp_dirty), .rsp_paddr(rsp_paddr)
   );

   function automatic logic [19:0] vpn_of(input int i);
      return 20'h12300 + 20'(i * 37);
   endfunction

   function automatic logic [19:0] pfn_of(input int i);
      return 20'hF0000 - 20'(i * 53);
   endfunction

   function automatic bit allowed(input logic [2:0] p, input logic [1:0] a);
      case (a)
         2'b00:   return p[0];
         2'b01:   return p[1];
         2'b10:   return p[2];
         default: return 1'b0;
      endcase
   endfunction

   task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got hit/miss/fault/dirty/paddr=%h expected %h", req, act, exp);
      end
   endtask

   // One clock step from a negative edge: drive, wait, release, then compare
   task automatic step(input bit lk, input logic [31:0] va, input logic [1:0] acc,
                       input bit fl, input int idx, input bit fv, input logic [19:0] fvpn,
                       input logic [19:0] fpfn, input logic [2:0] fperm, input bit fd,
                       input bit fs, input string req);
      int best = -1;
      bit ok;
      logic [35:0] exp;
      for (int i = 0; i < N; i++)
         if (best < 0 && m_v[i] && m_vpn[i] == va[31:12]) best = i;
      if (!lk)
         exp = {4'b0000, last_pa};
      else if (best < 0)
         exp = {4'b0100, 32'h0};
      else begin
         ok  = allowed(m_perm[best], acc);
         exp = {1'b1, 1'b0, !ok, m_d[best] | (acc == 2'b01 && ok), m_pfn[best], va[11:0]};
      end
      lk_valid = lk; lk_vaddr = va; lk_acc = acc;
      fl_en = fl; fl_idx = 4'(idx); fl_valid = fv; fl_vpn = fvpn;
      fl_pfn = fpfn; fl_perm = fperm; fl_dirty = fd; flush_all = fs;
      @(negedge clk);
      lk_valid = 1'b0; fl_en = 1'b0; flush_all = 1'b0;
      if (fs) begin
         for (int i = 0; i < N; i++) m_v[i] = 1'b0;
      end else begin
         if (lk && best >= 0 && acc == 2'b01 && allowed(m_perm[best], acc)) m_d[best] = 1'b1;
         if (fl) begin
            m_v[idx] = fv; m_d[idx] = fd; m_vpn[idx] = fvpn;
            m_pfn[idx] = fpfn; m_perm[idx] = fperm;
         end
      end
      if (lk) last_pa = exp[31:0];
      check(req, {rsp_hit, rsp_miss, rsp_fault, rsp_dirty, rsp_paddr}, exp);
   endtask

   task automatic lookup(input logic [31:0] va, input logic [1:0] acc, input string req);
      step(1'b1, va, acc, 1'b0, 0, 1'b0, '0, '0, '0, 1'b0, 1'b0, req);
   endtask

   task automatic fill(input int idx, input bit fv, input logic [19:0] fvpn,
                       input logic [19:0] fpfn, input logic [2:0] fperm, input bit fd);
      step(1'b0, '0, 2'b00, 1'b1, idx, fv, fvpn, fpfn, fperm, fd, 1'b0, "R8 fill idle");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: run did not complete, got hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         m_v[i] = 0; m_d[i] = 0; m_vpn[i] = '0; m_pfn[i] = '0; m_perm[i] = '0;
      end
      repeat (3) @(negedge clk);
      // R1: outputs cleared while reset is held
      check("R1 reset outputs", {rsp_hit, rsp_miss, rsp_fault, rsp_dirty, rsp_paddr}, 36'h0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: empty table after reset
      lookup({vpn_of(0), 12'h000}, 2'b00, "R1 lookup after reset");

      // R8: populate every entry, all permission patterns twice
      for (int i = 0; i < N; i++)
         fill(i, 1'b1, vpn_of(i), pfn_of(i), 3'(i), i[3]);

      // R3 R5 R6 sweep: each entry under each access code
      for (int i = 0; i < N; i++)
         for (int a = 0; a < 4; a++)
            lookup({vpn_of(i), 12'((i * 97 + a * 411 + 5) & 12'hFFF)}, 2'(a),
                   "R3 R5 R6 sweep");

      // R6 R7: modified flag after the sweep, read back with a read access
      for (int i = 0; i < N; i++)
         lookup({vpn_of(i), 12'hABC}, 2'b00, "R6 R7 modified readback");

      // R4: page numbers absent from the table
      for (int i = 0; i < N; i++)
         lookup({vpn_of(i) ^ 20'h80000, 12'(i)}, 2'(i), "R4 miss");

      // R2: no strobe leaves flags low, paddr held
      lookup({vpn_of(4), 12'h123}, 2'b00, "R2 lookup before idle");
      step(1'b0, '0, 2'b00, 1'b0, 0, 1'b0, '0, '0, '0, 1'b0, 1'b0, "R2 idle cycle");

      // R8: lookup in the same cycle as a fill sees old contents
      step(1'b1, {20'hBEEF0, 12'h044}, 2'b00, 1'b1, 3, 1'b1, 20'hBEEF0, 20'h0CAFE,
           3'b111, 1'b0, 1'b0, "R8 same-cycle fill not visible");
      lookup({20'hBEEF0, 12'h044}, 2'b00, "R8 fill visible next cycle");
      lookup({vpn_of(3), 12'h044}, 2'b00, "R8 overwritten page gone");
      fill(5, 1'b0, vpn_of(5), pfn_of(5), 3'b111, 1'b0);
      lookup({vpn_of(5), 12'h001}, 2'b00, "R8 fill with valid 0 removes");

      // R8: fill overrides a modified-flag update to the same entry
      fill(6, 1'b1, 20'h77770, 20'h11111, 3'b011, 1'b0);
      step(1'b1, {20'h77770, 12'h010}, 2'b01, 1'b1, 6, 1'b1, 20'h77770, 20'h22222,
           3'b011, 1'b0, 1'b0, "R8 write hit during fill");
      lookup({20'h77770, 12'h010}, 2'b00, "R8 fill beats modified update");

      // R10: duplicate page number, lowest index wins
      fill(9, 1'b1, 20'h5A5A5, 20'h09999, 3'b001, 1'b0);
      fill(2, 1'b1, 20'h5A5A5, 20'h02222, 3'b001, 1'b0);
      lookup({20'h5A5A5, 12'hFFF}, 2'b00, "R10 lowest index wins");
      fill(2, 1'b0, 20'h5A5A5, 20'h02222, 3'b001, 1'b0);
      lookup({20'h5A5A5, 12'h800}, 2'b00, "R10 next match after removal");

      // R9: invalidate beats a same-cycle fill, table empty afterwards
      step(1'b0, '0, 2'b00, 1'b1, 0, 1'b1, 20'h33333, 20'h44444, 3'b111, 1'b0,
           1'b1, "R9 flush cycle");
      lookup({20'h33333, 12'h000}, 2'b00, "R9 fill lost to flush");
      for (int i = 0; i < N; i++)
         lookup({vpn_of(i), 12'h0F0}, 2'b00, "R9 all entries gone");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule